// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address stream for synchronous burst reads out of a wide memory array. A burst is opened by a one-cycle `start` pulse while `chip_en` is high. On that clock edge the sequencer latches five settings: the start address, the burst-length code, the ordering bit, the first-data latency and the word-width bit. It then counts the latency cycles and issues one array address per clock, with `dvalid` marking the cycles where the array output belongs to the burst.

Fixed bursts of 4, 8 or 16 words stay inside an aligned block of the burst length. The order within that block is either linear with wrap-around or interleaved, where the low bits of the start word index are XORed with a beat counter. A continuous burst walks linearly through the whole array and wraps from the top address to zero. It runs until `chip_en` is dropped or a new burst is started. In 32-bit mode the address port still counts 16-bit units, so every step covers two units.

Top module: `burst_seq`

## Requirements
- R1: Settings are taken only on a clock edge where `start` and `chip_en` are both 1. Changing `start_addr`, `len_code`, `order_il`, `lat` or `wide` afterwards has no effect on the running burst. A `start` with `chip_en` at 0 is ignored, and `dvalid` stays 0.
- R2: With the start edge counted as edge 0, `dvalid` first goes high after edge `lat`. A `lat` of 0 behaves as 1. During the latency cycles `dvalid` is 0.
- R3: `len_code` 0, 1 and 2 select fixed bursts of 4, 8 and 16 words. In a fixed burst, `dvalid` is high on exactly that many consecutive clocks, with one new address per clock, and is then 0.
- R4: With `order_il`=0 in fixed mode, beat i addresses word index `B + ((S + i) mod L)`. Here S is the start word index modulo L, L is the burst length and B is the start word index rounded down to a multiple of L.
- R5: With `order_il`=1 in fixed mode, beat i addresses word index `B + (S XOR i)`, using the same B, S and L as in R4.
- R6: `len_code` 3 selects continuous mode. Beat i addresses word index (start word index + i) modulo the array size. `order_il` is ignored, and the burst has no end of its own.
- R7: With `wide`=1, a word is 32 bits. The word index is `start_addr` divided by 2, with bit 0 of `start_addr` ignored, and `arr_addr` is twice the word index, so bit 0 is always 0. With `wide`=0, `arr_addr` equals the word index.
- R8: When `chip_en` is 0, `dvalid` is 0 in the same cycle. The sequencer is idle after the next edge and stays idle after `chip_en` returns to 1, until a new start.
- R9: A new start during a running burst abandons the old burst and begins the new one with the new settings and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, up to 50 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Enable; 0 aborts any burst |
| start | input | 1 | Burst start pulse |
| start_addr | input | ADDR_W | First address, in 16-bit units |
| len_code | input | 2 | 0:4, 1:8, 2:16 words, 3: continuous |
| order_il | input | 1 | 1 selects interleaved order |
| lat | input | LAT_W | Clocks from start to first valid beat |
| wide | input | 1 | 1 selects 32-bit words |
| arr_addr | output | ADDR_W | Array address, in 16-bit units |
| dvalid | output | 1 | High on each beat of the burst |

## Verification
The bench drives inputs on the falling edge and samples on the falling edge. Sample n after a start therefore follows n rising edges. `dvalid` is expected to be high from sample `lat`+1 (a `lat` of 0 counts as 1), for L samples, and beat i belongs to sample `lat`+1+i. The testbench memory model registers the read on the rising edge, so its data for beat i is checked one sample after that beat's address. The effect of `chip_en` on `dvalid` is combinational, so an abort is checked 1 ns after the drop and then again on the following samples.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_t;

   localparam logic [1:0] LEN_CONT = 2'd3;

   // Fixed burst length in words for codes 0..2.
   function automatic int unsigned beats_of(input logic [1:0] code);
      return 32'd4 << code;
   endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        len_code,
   input  logic              order_il,
   input  logic              wide,
   output logic [ADDR_W-1:0] base_q,
   output logic [1:0]        len_q,
   output logic              il_q,
   output logic              wide_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         il_q   <= 1'b0;
         wide_q <= 1'b0;
      end else if (load) begin
         base_q <= start_addr;
         len_q  <= len_code;
         il_q   <= order_il;
         wide_q <= wide;
      end
   end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LAT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              load,
   input  logic [LAT_W-1:0]  lat,
   input  logic [1:0]        len_q,
   output logic [ADDR_W-1:0] beat,
   output logic              run
);

   localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

   seq_state_t        state;
   logic [LAT_W-1:0]  wait_cnt;
   logic [LAT_W-1:0]  lat_eff;
   logic              last_beat;

   assign lat_eff   = (lat == '0) ? LAT_ONE : lat;
   assign last_beat = (len_q != LEN_CONT) &&
                      (beat == ADDR_W'(beats_of(len_q) - 1));
   assign run       = (state == ST_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wait_cnt <= '0;
         beat     <= '0;
      end else if (!chip_en) begin
         state    <= ST_IDLE;
      end else if (load) begin
         state    <= ST_WAIT;
         wait_cnt <= lat_eff;
         beat     <= '0;
      end else begin
         unique case (state)
            ST_WAIT: begin
               if (wait_cnt == LAT_ONE) state <= ST_RUN;
               else                     wait_cnt <= wait_cnt - LAT_ONE;
            end
            ST_RUN: begin
               beat <= beat + ADDR_W'(1);
               if (last_beat) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic [ADDR_W-1:0] base_q,
   input  logic [ADDR_W-1:0] beat,
   input  logic [1:0]        len_q,
   input  logic              il_q,
   input  logic              wide_q,
   output logic [ADDR_W-1:0] arr_addr
);

   logic              wide_eff;
   logic [ADDR_W-1:0] wstart;
   logic [ADDR_W-1:0] blk_mask;
   logic [ADDR_W-1:0] lin_word;
   logic [ADDR_W-1:0] low_word;
   logic [ADDR_W-1:0] fixed_word;
   logic [ADDR_W-1:0] word;

   if (ALLOW_WIDE) begin : g_wide
      assign wide_eff = wide_q;
   end else begin : g_narrow
      assign wide_eff = 1'b0;
   end

   assign wstart   = wide_eff ? {1'b0, base_q[ADDR_W-1:1]} : base_q;
   assign blk_mask = (ADDR_W'(4) << len_q) - ADDR_W'(1);
   assign lin_word = wstart + beat;
   assign low_word = il_q ? (wstart ^ beat) : lin_word;

   // Bitwise merge: offset bits from the ordered low part, block bits fixed.
   for (genvar b = 0; b < ADDR_W; b++) begin : g_merge
      assign fixed_word[b] = blk_mask[b] ? low_word[b] : wstart[b];
   end

   assign word     = (len_q == LEN_CONT) ? lin_word : fixed_word;
   assign arr_addr = wide_eff ? {word[ADDR_W-2:0], 1'b0} : word;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LAT_W      = 3,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        len_code,
   input  logic              order_il,
   input  logic [LAT_W-1:0]  lat,
   input  logic              wide,
   output logic [ADDR_W-1:0] arr_addr,
   output logic              dvalid
);

   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr_w
      $error("burst_seq: ADDR_W must lie in 6..32");
   end
   if (LAT_W < 1 || LAT_W > 8) begin : g_bad_lat_w
      $error("burst_seq: LAT_W must lie in 1..8");
   end

   logic              load;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        len_q;
   logic              il_q;
   logic              wide_q;
   logic [ADDR_W-1:0] beat;
   logic              run;

   assign load = start & chip_en;

   burst_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load),
      .start_addr(start_addr), .len_code(len_code),
      .order_il(order_il), .wide(wide),
      .base_q(base_q), .len_q(len_q), .il_q(il_q), .wide_q(wide_q)
   );

   burst_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .load(load),
      .lat(lat), .len_q(len_q), .beat(beat), .run(run)
   );

   burst_addr_gen #(.ADDR_W(ADDR_W), .ALLOW_WIDE(ALLOW_WIDE)) u_agen (
      .base_q(base_q), .beat(beat), .len_q(len_q), .il_q(il_q),
      .wide_q(wide_q), .arr_addr(arr_addr)
   );

   assign dvalid = run & chip_en;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int ADDR_W     = 16,
   parameter int LAT_W      = 3,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              start,
   input logic [ADDR_W-1:0] start_addr,
   input logic [1:0]        len_code,
   input logic              order_il,
   input logic [LAT_W-1:0]  lat,
   input logic              wide,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              dvalid
);

   logic              armed;
   logic [ADDR_W-1:0] sa_q;
   logic [1:0]        ln_q;
   logic              wd_q;
   logic [LAT_W:0]    lat_q;
   logic [LAT_W:0]    since;
   logic [5:0]        beats;
   logic              cont_q;
   logic [5:0]        blen;
   logic [ADDR_W-1:0] bmask;
   logic [ADDR_W-1:0] step;

   assign cont_q = (ln_q == 2'd3);
   assign blen   = 6'd4 << ln_q;
   assign bmask  = ((ADDR_W'(4) << ln_q) << wd_q) - ADDR_W'(1);
   assign step   = wd_q ? ADDR_W'(2) : ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0; sa_q <= '0; ln_q <= '0; wd_q <= 1'b0;
         lat_q <= '0; since <= '0; beats <= '0;
      end else begin
         if (!chip_en) armed <= 1'b0;
         else if (start) armed <= 1'b1;
         if (start && chip_en) begin
            sa_q  <= start_addr;
            ln_q  <= len_code;
            wd_q  <= wide & ALLOW_WIDE;
            lat_q <= (lat == '0) ? (LAT_W+1)'(1) : {1'b0, lat};
            since <= '0;
            beats <= '0;
         end else begin
            if (since != '1) since <= since + 1'b1;
            if (dvalid && beats != '1) beats <= beats + 6'd1;
         end
      end
   end

   // R2: first valid beat arrives exactly lat edges after the start edge
   a_r2_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dvalid) |-> since == lat_q);

   // R3: a fixed burst never delivers more beats than its length
   a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !cont_q) |-> beats < blen);

   // R4/R5: fixed bursts stay inside the aligned block
   a_r4_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !cont_q) |-> ((arr_addr ^ sa_q) & ~bmask) == '0);

   // R6: continuous mode advances one word per clock, wrapping at the top
   a_r6_cont_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(dvalid) && cont_q) |-> arr_addr == $past(arr_addr) + step);

   // R7: 32-bit words are always even in 16-bit units
   a_r7_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && wd_q) |-> !arr_addr[0]);

   // R8: no beat without an accepted start since the last disable
   a_r8_armed: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> armed);

endmodule

bind burst_seq burst_seq_chk #(
   .ADDR_W(ADDR_W), .LAT_W(LAT_W), .ALLOW_WIDE(ALLOW_WIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start(start),
   .start_addr(start_addr), .len_code(len_code), .order_il(order_il),
   .lat(lat), .wide(wide), .arr_addr(arr_addr), .dvalid(dvalid)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_addr = '0;
   logic [1:0]  len_code = '0;
   logic        order_il = 1'b0;
   logic [2:0]  lat = '0;
   logic        wide = 1'b0;
   logic [15:0] arr_addr;
   logic        dvalid;
   logic [15:0] rd_q = '0;
   int          ncheck = 0;
   int          nerr = 0;

   always #10 clk = ~clk;

   burst_seq u0 (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start(start),
      .start_addr(start_addr), .len_code(len_code), .order_il(order_il),
      .lat(lat), .wide(wide), .arr_addr(arr_addr), .dvalid(dvalid)
   );

   // Synchronous array model: data is a fixed scramble of the address.
   always_ff @(posedge clk) if (dvalid) rd_q <= arr_addr ^ 16'hC3A5;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      ncheck++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [15:0] sa, input logic [1:0] ls,
                                            input logic il, input logic wd, input int i);
      int unsigned u  = wd ? 2 : 1;
      int unsigned ws = sa / u;
      int unsigned nb = 4 << ls;
      int unsigned w;
      if (ls == 2'd3) w = ws + i;
      else if (il)    w = ws - (ws % nb) + ((ws % nb) ^ i);
      else            w = ws - (ws % nb) + (((ws % nb) + i) % nb);
      return 16'((w * u) % 65536);
   endfunction

   task automatic t_reset();
      chk(dvalid == 1'b0, "reset dvalid", 32'(dvalid), 0);
   endtask

   // Start a burst and check ncyc falling-edge samples after it (0 = whole burst).
   task automatic run_burst(input logic [15:0] sa, input logic [1:0] ls, input logic il,
                            input logic [2:0] lt, input logic wd, input int ncyc,
                            input string rq);
      int le = (lt == 0) ? 1 : lt;
      int nb = (ls == 2'd3) ? 0 : (4 << ls);
      int n  = (ncyc != 0) ? ncyc : le + nb + 3;
      @(negedge clk);
      chip_en = 1'b1; start = 1'b1; start_addr = sa; len_code = ls;
      order_il = il; lat = lt; wide = wd;
      for (int c = 1; c <= n; c++) begin
         @(negedge clk);
         start = 1'b0;
         // R1: scramble the settings after the start edge
         start_addr = ~sa; len_code = ls ^ 2'd1; order_il = ~il; lat = ~lt; wide = ~wd;
         begin
            bit ev  = (c >= le + 1) && (nb == 0 || c < le + 1 + nb);
            bit evp = (c - 1 >= le + 1) && (nb == 0 || c - 1 < le + 1 + nb);
            chk(dvalid == ev, {rq, " dvalid R3"}, 32'(dvalid), 32'(ev));
            if (ev) chk(arr_addr == exp_addr(sa, ls, il, wd, c - le - 1),
                        {rq, " address"}, 32'(arr_addr),
                        32'(exp_addr(sa, ls, il, wd, c - le - 1)));
            if (evp) chk(rd_q == (exp_addr(sa, ls, il, wd, c - le - 2) ^ 16'hC3A5),
                         {rq, " read data"}, 32'(rd_q),
                         32'(exp_addr(sa, ls, il, wd, c - le - 2) ^ 16'hC3A5));
         end
      end
   endtask

   task automatic t_abort(input string rq);
      @(negedge clk);
      chip_en = 1'b0;
      #1 chk(dvalid == 1'b0, {rq, " same-cycle drop"}, 32'(dvalid), 0);
      @(negedge clk);
      chk(dvalid == 1'b0, {rq, " idle"}, 32'(dvalid), 0);
      chip_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(dvalid == 1'b0, {rq, " stays idle"}, 32'(dvalid), 0);
      end
   endtask

   task automatic t_ign_start(input string rq);
      @(negedge clk);
      chip_en = 1'b0; start = 1'b1; start_addr = 16'h0040; len_code = 2'd0; lat = 3'd1;
      @(negedge clk);
      start = 1'b0; chip_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(dvalid == 1'b0, {rq, " start ignored"}, 32'(dvalid), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      run_burst(16'h0006, 2'd0, 1'b0, 3'd2, 1'b0, 0, "R4 seq4");
      run_burst(16'h0035, 2'd1, 1'b1, 3'd3, 1'b0, 0, "R5 il8");
      run_burst(16'h1239, 2'd2, 1'b0, 3'd5, 1'b1, 0, "R7 seq16 x32");
      run_burst(16'h00AE, 2'd0, 1'b1, 3'd1, 1'b1, 0, "R7 il4 x32");
      run_burst(16'h0043, 2'd2, 1'b1, 3'd0, 1'b0, 0, "R2 lat0");
      run_burst(16'h0010, 2'd1, 1'b0, 3'd7, 1'b0, 0, "R2 lat7");
      run_burst(16'hFFFA, 2'd3, 1'b1, 3'd2, 1'b0, 16, "R6 cont x16");
      t_abort("R8 cont");
      run_burst(16'hFFF8, 2'd3, 1'b0, 3'd1, 1'b1, 10, "R6 cont x32");
      t_abort("R8 cont x32");
      run_burst(16'h0100, 2'd2, 1'b0, 3'd2, 1'b0, 6, "R8 fixed");
      t_abort("R8 mid burst");
      run_burst(16'h0200, 2'd1, 1'b0, 3'd2, 1'b0, 5, "R9 first");
      run_burst(16'h0333, 2'd1, 1'b1, 3'd3, 1'b0, 0, "R9 restart");
      t_ign_start("R1");
      $display("CHECKS %0d ERRORS %0d", ncheck, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      ncheck++;
      nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", ncheck, nerr);
      $finish;
   end

endmodule